// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a multi-cycle processor core, built as a microcode engine instead of a hand-written state machine. A small micro-address register selects one word from a constant microcode store. The fields of that word are decoded at once into the datapath's control lines: ALU operation and operand selects, register-file write controls, memory and instruction-register strobes, and program-counter load controls. Each instruction passes through a fetch word and a decode word. It then runs a short completion sequence chosen by its opcode, and finally returns to fetch.

The 2-bit sequencing field of the current word picks the next micro-address. It can return to address 0, step to the next address, or jump through one of two constant dispatch tables. Each table has one entry for every value of the 6-bit opcode. The opcode input is used only on cycles whose word requests a dispatch. The block has no data stream, so every pin is a plain level signal, and no handshake or back-pressure applies.

Top module: `ucode_sequencer`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `uaddr` is 0 and the outputs show the fetch controls of R8.
- R2: Each microword has 18 bits. From MSB to LSB it holds: ALU op (2), operand A select (1), operand B select (2), register control (3), memory control (4), PC control (4), sequencing (2). Control outputs are decoded from the word at the current `uaddr` in the same cycle, with no register stage between them.
- R3: Sequencing code 00 makes the next `uaddr` equal to 0.
- R4: Sequencing code 11 makes the next `uaddr` equal to the current `uaddr` plus 1. Addresses 0, 3 and 6 use this code.
- R5: Sequencing code 01 (used at address 1) jumps through table 1. Opcode 0x23 (load) and 0x2B (store) go to 2, opcode 0x00 (register-register) goes to 6, 0x04 (branch-if-equal) goes to 8, and 0x02 (jump) goes to 9.
- R6: Sequencing code 10 (used at address 2) jumps through table 2. Opcode 0x23 goes to 3 and opcode 0x2B goes to 5. Addresses 4, 5, 7, 8 and 9 use code 00.
- R7: An opcode that is not listed in a dispatch table yields address 0, so the instruction ends and fetch resumes.
- R8: At address 0, `mem_rd`, `ir_load` and `pc_load` are 1, `alu_b_sel`=01, `alu_op`=00, `alu_a_sel`=0 and `pc_src`=00. All other strobes are 0.
- R9: At address 1, `alu_a_sel`=0, `alu_b_sel`=11 and `alu_op`=00. No write or memory strobe is active.
- R10: Address 2 gives `alu_a_sel`=1 and `alu_b_sel`=10. Address 3 gives `mem_rd`=1 and `addr_sel_alu`=1. Address 4 gives `reg_wr`=1 and `wb_sel_mem`=1. Address 5 gives `mem_wr`=1 and `addr_sel_alu`=1. All other outputs at these addresses are 0.
- R11: Address 6 gives `alu_op`=10 and `alu_a_sel`=1. Address 7 gives `reg_wr`=1 and `dst_sel_rd`=1. Address 8 gives `alu_op`=01, `alu_a_sel`=1, `pc_load_if_zero`=1 and `pc_src`=01. Address 9 gives `pc_load`=1 and `pc_src`=10. All other outputs at these addresses are 0.
- R12: A change of `opcode` has no effect on the next address at any address whose word does not request a dispatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode | input | 6 | Opcode of the instruction being executed |
| uaddr | output | 4 | Current micro-address |
| alu_op | output | 2 | ALU operation: 00 add, 01 subtract, 10 by function field |
| alu_a_sel | output | 1 | Operand A: 0 program counter, 1 register A |
| alu_b_sel | output | 2 | Operand B: 00 register B, 01 constant 4, 10 immediate, 11 immediate shifted by 2 |
| reg_wr | output | 1 | Register file write enable |
| wb_sel_mem | output | 1 | Write-back data from the memory data register instead of the ALU result |
| dst_sel_rd | output | 1 | Destination register from the rd field instead of rt |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| addr_sel_alu | output | 1 | Memory address from the ALU result register instead of the PC |
| ir_load | output | 1 | Instruction register load |
| pc_load | output | 1 | Unconditional PC load |
| pc_load_if_zero | output | 1 | PC load when the ALU zero flag is set |
| pc_src | output | 2 | PC source: 00 ALU, 01 ALU result register, 10 jump target |

## Verification
The control outputs depend only on `uaddr`, so they settle in the same cycle that `uaddr` changes. `uaddr` moves exactly one rising edge after the cycle whose sequencing field and opcode select it. The bench changes `opcode` 2 ns after a rising edge and samples `uaddr` and all controls at that same point. Each check therefore sees the address chosen at the edge just passed, and the controls of that address. The R12 scenario changes the opcode while a non-dispatch word is current, and then confirms the address after the following edge.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int UA_W = 4;
  localparam int OP_W = 6;
  localparam int UW_W = 18;

  localparam logic [OP_W-1:0] OPC_ALU   = 6'h00;
  localparam logic [OP_W-1:0] OPC_JMP   = 6'h02;
  localparam logic [OP_W-1:0] OPC_BEQ   = 6'h04;
  localparam logic [OP_W-1:0] OPC_LOAD  = 6'h23;
  localparam logic [OP_W-1:0] OPC_STORE = 6'h2B;

  typedef enum logic [1:0] {
    SQ_FETCH = 2'b00,
    SQ_DISP1 = 2'b01,
    SQ_DISP2 = 2'b10,
    SQ_NEXT  = 2'b11
  } seq_e;

  typedef struct packed {
    logic wr;
    logic from_mem;
    logic dst_rd;
  } rf_ctl_t;

  typedef struct packed {
    logic rd;
    logic wr;
    logic addr_alu;
    logic ir_ld;
  } mem_ctl_t;

  typedef struct packed {
    logic       ld;
    logic       ld_zero;
    logic [1:0] src;
  } pc_ctl_t;

  typedef struct packed {
    logic [1:0] alu_op;
    logic       a_sel;
    logic [1:0] b_sel;
    rf_ctl_t    rf;
    mem_ctl_t   mem;
    pc_ctl_t    pc;
    seq_e       seq;
  } uword_t;

  function automatic uword_t ucode_at(input int a);
    uword_t w;
    w = '0;
    w.seq = SQ_FETCH;
    case (a)
      0: begin
        w.b_sel     = 2'b01;
        w.mem.rd    = 1'b1;
        w.mem.ir_ld = 1'b1;
        w.pc.ld     = 1'b1;
        w.seq       = SQ_NEXT;
      end
      1: begin
        w.b_sel = 2'b11;
        w.seq   = SQ_DISP1;
      end
      2: begin
        w.a_sel = 1'b1;
        w.b_sel = 2'b10;
        w.seq   = SQ_DISP2;
      end
      3: begin
        w.mem.rd       = 1'b1;
        w.mem.addr_alu = 1'b1;
        w.seq          = SQ_NEXT;
      end
      4: begin
        w.rf.wr       = 1'b1;
        w.rf.from_mem = 1'b1;
      end
      5: begin
        w.mem.wr       = 1'b1;
        w.mem.addr_alu = 1'b1;
      end
      6: begin
        w.alu_op = 2'b10;
        w.a_sel  = 1'b1;
        w.seq    = SQ_NEXT;
      end
      7: begin
        w.rf.wr     = 1'b1;
        w.rf.dst_rd = 1'b1;
      end
      8: begin
        w.alu_op     = 2'b01;
        w.a_sel      = 1'b1;
        w.pc.ld_zero = 1'b1;
        w.pc.src     = 2'b01;
      end
      9: begin
        w.pc.ld  = 1'b1;
        w.pc.src = 2'b10;
      end
      default: w = '0;
    endcase
    return w;
  endfunction

  function automatic logic [UA_W-1:0] dispatch_at(input int table_id, input int op);
    logic [UA_W-1:0] t;
    t = '0;
    if (table_id == 1) begin
      if (op == int'(OPC_LOAD) || op == int'(OPC_STORE)) t = 4'd2;
      else if (op == int'(OPC_ALU)) t = 4'd6;
      else if (op == int'(OPC_BEQ)) t = 4'd8;
      else if (op == int'(OPC_JMP)) t = 4'd9;
    end else begin
      if (op == int'(OPC_LOAD)) t = 4'd3;
      else if (op == int'(OPC_STORE)) t = 4'd5;
    end
    return t;
  endfunction

endpackage

// File: rtl/useq_store.sv
module useq_store
  import useq_pkg::*;
#(
  parameter int AW = UA_W
) (
  input  logic [AW-1:0] addr,
  output uword_t        word
);
  localparam int DEPTH = 1 << AW;

  uword_t rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    assign rom[i] = ucode_at(i);
  end

  assign word = rom[addr];
endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch
  import useq_pkg::*;
#(
  parameter int OW       = OP_W,
  parameter int AW       = UA_W,
  parameter int TABLE_ID = 1
) (
  input  logic [OW-1:0] opcode,
  output logic [AW-1:0] target
);
  localparam int DEPTH = 1 << OW;

  logic [AW-1:0] tbl [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    assign tbl[i] = dispatch_at(TABLE_ID, i);
  end

  assign target = tbl[opcode];
endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
#(
  parameter int AW = UA_W
) (
  input  seq_e          seq,
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] disp1,
  input  logic [AW-1:0] disp2,
  output logic [AW-1:0] nxt
);
  always_comb begin
    unique case (seq)
      SQ_FETCH: nxt = '0;
      SQ_DISP1: nxt = disp1;
      SQ_DISP2: nxt = disp2;
      SQ_NEXT:  nxt = cur + 1'b1;
      default:  nxt = '0;
    endcase
  end
endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer
  import useq_pkg::*;
#(
  parameter int AW = UA_W,
  parameter int OW = OP_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [OW-1:0] opcode,
  output logic [AW-1:0] uaddr,
  output logic [1:0]    alu_op,
  output logic          alu_a_sel,
  output logic [1:0]    alu_b_sel,
  output logic          reg_wr,
  output logic          wb_sel_mem,
  output logic          dst_sel_rd,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          addr_sel_alu,
  output logic          ir_load,
  output logic          pc_load,
  output logic          pc_load_if_zero,
  output logic [1:0]    pc_src
);
  logic [AW-1:0] upc_q;
  logic [AW-1:0] upc_d;
  logic [AW-1:0] tgt1;
  logic [AW-1:0] tgt2;
  uword_t        uw;

  useq_store #(.AW(AW)) u_store (
    .addr (upc_q),
    .word (uw)
  );

  useq_dispatch #(.OW(OW), .AW(AW), .TABLE_ID(1)) u_disp1 (
    .opcode (opcode),
    .target (tgt1)
  );

  useq_dispatch #(.OW(OW), .AW(AW), .TABLE_ID(2)) u_disp2 (
    .opcode (opcode),
    .target (tgt2)
  );

  useq_next #(.AW(AW)) u_next (
    .seq   (uw.seq),
    .cur   (upc_q),
    .disp1 (tgt1),
    .disp2 (tgt2),
    .nxt   (upc_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upc_q <= '0;
    else        upc_q <= upc_d;
  end

  assign uaddr           = upc_q;
  assign alu_op          = uw.alu_op;
  assign alu_a_sel       = uw.a_sel;
  assign alu_b_sel       = uw.b_sel;
  assign reg_wr          = uw.rf.wr;
  assign wb_sel_mem      = uw.rf.from_mem;
  assign dst_sel_rd      = uw.rf.dst_rd;
  assign mem_rd          = uw.mem.rd;
  assign mem_wr          = uw.mem.wr;
  assign addr_sel_alu    = uw.mem.addr_alu;
  assign ir_load         = uw.mem.ir_ld;
  assign pc_load         = uw.pc.ld;
  assign pc_load_if_zero = uw.pc.ld_zero;
  assign pc_src          = uw.pc.src;

  // R3: a fetch code leads back to address 0
  a_r3_fetch_return: assert property (@(posedge clk) disable iff (!rst_n)
    (uw.seq == SQ_FETCH) |=> (upc_q == '0));

  // R4: the increment code steps the address by one
  a_r4_increment: assert property (@(posedge clk) disable iff (!rst_n)
    (uw.seq == SQ_NEXT) |=> (upc_q == $past(upc_q) + 1'b1));

  // R5: after decode only a table 1 target or fetch is reachable
  a_r5_decode_targets: assert property (@(posedge clk) disable iff (!rst_n)
    (upc_q == 4'd1) |=> (upc_q == 4'd0 || upc_q == 4'd2 || upc_q == 4'd6 ||
                         upc_q == 4'd8 || upc_q == 4'd9));

  // R6: after address computation only a table 2 target or fetch is reachable
  a_r6_mem_targets: assert property (@(posedge clk) disable iff (!rst_n)
    (upc_q == 4'd2) |=> (upc_q == 4'd0 || upc_q == 4'd3 || upc_q == 4'd5));

  // R8: fetch word reads memory, loads the instruction and advances the PC
  a_r8_fetch_controls: assert property (@(posedge clk) disable iff (!rst_n)
    (upc_q == '0) |-> (mem_rd && ir_load && pc_load && !mem_wr && !reg_wr));

  // R10: memory read and write never in the same cycle
  a_r10_mem_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd, mem_wr}));
endmodule

// File: tb/ucode_sequencer_test.sv
module ucode_sequencer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] opcode = 6'h00;
  logic [3:0] uaddr;
  logic [1:0] alu_op, alu_b_sel, pc_src;
  logic       alu_a_sel, reg_wr, wb_sel_mem, dst_sel_rd, mem_rd, mem_wr;
  logic       addr_sel_alu, ir_load, pc_load, pc_load_if_zero;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ucode_sequencer uut (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .uaddr(uaddr),
    .alu_op(alu_op), .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel),
    .reg_wr(reg_wr), .wb_sel_mem(wb_sel_mem), .dst_sel_rd(dst_sel_rd),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .addr_sel_alu(addr_sel_alu),
    .ir_load(ir_load), .pc_load(pc_load), .pc_load_if_zero(pc_load_if_zero),
    .pc_src(pc_src)
  );

  // {alu_op, a_sel, b_sel, reg_wr, wb_mem, dst_rd, mem_rd, mem_wr, addr_alu, ir_load, pc_load, pc_zero, pc_src}
  function automatic logic [15:0] exp_ctl(input int a);
    case (a)
      0: return 16'b00_0_01_000_1001_1000;
      1: return 16'b00_0_11_000_0000_0000;
      2: return 16'b00_1_10_000_0000_0000;
      3: return 16'b00_0_00_000_1010_0000;
      4: return 16'b00_0_00_110_0000_0000;
      5: return 16'b00_0_00_000_0110_0000;
      6: return 16'b10_1_00_000_0000_0000;
      7: return 16'b00_0_00_101_0000_0000;
      8: return 16'b01_1_00_000_0000_0101;
      9: return 16'b00_0_00_000_0000_1010;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic string ctl_tag(input int a);
    if (a == 0) return "R8";
    if (a == 1) return "R9";
    if (a <= 5) return "R10";
    return "R11";
  endfunction

  function automatic logic [15:0] act_ctl();
    return {alu_op, alu_a_sel, alu_b_sel, reg_wr, wb_sel_mem, dst_sel_rd,
            mem_rd, mem_wr, addr_sel_alu, ir_load, pc_load, pc_load_if_zero, pc_src};
  endfunction

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk_addr(input string tag, input int expv);
    checks++;
    if (int'(uaddr) != expv) begin
      errors++;
      $display("FAIL %s uaddr got %0d exp %0d", tag, uaddr, expv);
    end
  endtask

  task automatic chk_ctl(input int a);
    checks++;
    if (act_ctl() !== exp_ctl(a)) begin
      errors++;
      $display("FAIL %s/R2 controls at %0d got %b exp %b", ctl_tag(a), a, act_ctl(), exp_ctl(a));
    end
  endtask

  // R1: reset state
  task automatic t_reset();
    rst_n = 1'b0;
    #3;
    chk_addr("R1", 0);
    chk_ctl(0);
    repeat (2) tick();
    chk_addr("R1", 0);
    rst_n = 1'b1;
    tick();
    chk_addr("R1", 1);
    rst_n = 1'b0;
    #1;
    chk_addr("R1", 0);
    chk_ctl(0);
    tick();
    rst_n = 1'b1;
    #1;
    chk_addr("R1", 0);
  endtask

  // Walk one instruction; path holds addresses, lowest nibble first.
  task automatic t_path(input string tag, input logic [5:0] op, input int len,
                        input logic [23:0] path);
    opcode = op;
    for (int i = 0; i < len; i++) begin
      chk_addr(tag, int'(path[4*i +: 4]));
      chk_ctl(int'(path[4*i +: 4]));
      tick();
    end
    chk_addr("R3", 0);
  endtask

  // R7: unlisted opcodes return to fetch from decode
  task automatic t_unlisted();
    logic [5:0] ops [4] = '{6'h01, 6'h3F, 6'h2A, 6'h05};
    foreach (ops[k]) begin
      opcode = ops[k];
      chk_addr("R4", 0);
      tick();
      chk_addr("R4", 1);
      tick();
      chk_addr("R7", 0);
    end
  endtask

  // R12: opcode changes away from dispatch words have no effect
  task automatic t_ignore();
    opcode = 6'h04;
    tick();
    chk_addr("R12", 1);
    opcode = 6'h00;
    tick();
    chk_addr("R5", 6);
    opcode = 6'h23;
    tick();
    chk_addr("R12", 7);
    opcode = 6'h2B;
    tick();
    chk_addr("R12", 0);
    opcode = 6'h23;
    tick();
    opcode = 6'h23;
    tick();
    chk_addr("R5", 2);
    opcode = 6'h2B;
    tick();
    chk_addr("R6", 5);
    opcode = 6'h02;
    tick();
    chk_addr("R12", 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_path("R6", 6'h23, 5, {4'd0, 4'd4, 4'd3, 4'd2, 4'd1, 4'd0});
    t_path("R6", 6'h2B, 4, {4'd0, 4'd0, 4'd5, 4'd2, 4'd1, 4'd0});
    t_path("R5", 6'h00, 4, {4'd0, 4'd0, 4'd7, 4'd6, 4'd1, 4'd0});
    t_path("R5", 6'h04, 3, {4'd0, 4'd0, 4'd0, 4'd8, 4'd1, 4'd0});
    t_path("R5", 6'h02, 3, {4'd0, 4'd0, 4'd0, 4'd9, 4'd1, 4'd0});
    t_unlisted();
    t_ignore();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule